// File: doc/BRIEF.md
# I2C Message Sequencer

This block walks a list of I2C message descriptors and drives a byte-level I2C master controller one command at a time. Without it, software would handle an interrupt for every byte. Each descriptor carries a 7-bit target address, a direction bit, a flag that continues the previous message without a new address phase, a byte count, and a marker for the final message of the list. Bytes to transmit arrive on a ready/valid stream. Received bytes leave on a valid-only stream. The block reacts to each byte-complete event from the controller, picks the next command, and finally reports success, an I/O error or a timeout.

A transfer is launched with a one-cycle `go` pulse. From then on the sequencer pulls descriptors as it needs them. It issues at most one command and then waits for that command's completion event. Each time a message ends, the next message opens with a repeated start and its address byte, unless it asked for a continuation. Every transfer closes with a stop command followed by an interrupt-acknowledge command. The only exception is a timeout, which abandons the transfer without issuing either.

Top module: `i2c_msg_seq`

## Requirements
- R1: The first command of every transfer is START_WR (`cmd_op`=0). Its `cmd_byte` is the address in bits 7:1, and bit 0 is 1 for a read message and 0 for a write message.
- R2: Each write byte is taken from the write stream in the cycle its WR command (`cmd_op`=1) is formed. `cmd_valid` follows on the next clock edge with that byte in `cmd_byte`. While the stream has no data, no command is issued and the engine stays busy.
- R3: A read message of N bytes issues N read commands. The last of them is RD_NACK (`cmd_op`=3) and all earlier ones are RD_ACK (`cmd_op`=2). Each received byte appears once on `rd_data` with `rd_valid`, in order.
- R4: When a message ends and another remains, the next message opens with START_WR and its address byte. If that next message has its continuation flag set, it goes straight to data commands with no START_WR.
- R5: A completion event with `evt_nack` set, after an address or write byte, makes the next command STOP (`cmd_op`=4). The transfer then ends with status IOERR (1).
- R6: A completion event with `evt_arblost` set, in any data or address phase, makes the next command STOP. The transfer then ends with status IOERR (1).
- R7: After the last message the engine issues STOP. On STOP's completion event it issues IACK (`cmd_op`=5), pulses `xfer_done`, drops `busy` and reports status OK (0).
- R8: If the transfer has not ended `tmo_limit` cycles after launch, it ends with status TIMEOUT (2) and `busy` drops, independently of the I/O error path.
- R9: A zero-length message issues no data command. A zero-length continuation message issues no command at all.
- R10: After reset, `busy`, `cmd_valid`, `desc_ready`, `wr_ready`, `rd_valid` and `xfer_done` are all 0.
- R11: No new command is issued while a previously issued command (other than IACK) still awaits its completion event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Launch pulse, ignored while busy |
| tmo_limit | input | TMO_W | Timeout in cycles from launch |
| desc_valid | input | 1 | Descriptor available |
| desc_ready | output | 1 | Descriptor taken this cycle |
| desc_addr | input | 7 | Target address |
| desc_rd | input | 1 | 1 = read message |
| desc_nostart | input | 1 | 1 = continue without address phase |
| desc_len | input | LEN_W | Message byte count |
| desc_last | input | 1 | Final message of the list |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte taken this cycle |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Received byte strobe |
| rd_data | output | 8 | Received byte |
| cmd_valid | output | 1 | Command strobe to byte controller |
| cmd_op | output | 3 | 0 START_WR, 1 WR, 2 RD_ACK, 3 RD_NACK, 4 STOP, 5 IACK |
| cmd_byte | output | 8 | Byte for START_WR or WR |
| evt_done | input | 1 | Byte-complete event |
| evt_nack | input | 1 | Target did not acknowledge |
| evt_arblost | input | 1 | Arbitration lost |
| evt_rxbyte | input | 8 | Received byte with the event |
| busy | output | 1 | Transfer in progress |
| xfer_done | output | 1 | One-cycle end-of-transfer strobe |
| xfer_status | output | 2 | 0 OK, 1 IOERR, 2 TIMEOUT |

## Verification
A wrong phase or byte position inside the sequencer shows at the ports on the very next command. It can appear as a missing or extra START_WR, an ACK where a NACK belongs, a byte taken from the wrong place, or a STOP that comes too early. Each command is logged and compared in order against a sequence computed from the descriptor list, so a divergence is seen within one byte time. A stuck state shows up as a missing `xfer_done`, or as a late one in the timeout case, within the bench's wait bound. Error handling is checked by injecting NACK and lost arbitration at chosen command indices. After each injection the bench checks that STOP and IACK follow at once.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

   typedef enum logic [2:0] {
      OP_START_WR = 3'd0,
      OP_WR       = 3'd1,
      OP_RD_ACK   = 3'd2,
      OP_RD_NACK  = 3'd3,
      OP_STOP     = 3'd4,
      OP_IACK     = 3'd5
   } cmd_op_e;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_START = 3'd1,
      PH_WRITE = 3'd2,
      PH_READ  = 3'd3,
      PH_DONE  = 3'd4,
      PH_ERROR = 3'd5
   } phase_e;

   typedef enum logic [1:0] {
      ACT_WAIT  = 2'd0,
      ACT_FETCH = 2'd1,
      ACT_DATA  = 2'd2
   } act_e;

   typedef enum logic [1:0] {
      ST_OK      = 2'd0,
      ST_IOERR   = 2'd1,
      ST_TIMEOUT = 2'd2
   } xfer_st_e;

endpackage

// File: rtl/i2cseq_pos.sv
module i2cseq_pos #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] len,
   input  logic             inc,
   output logic             at_end,
   output logic             at_last
);
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q <= '0;
         pos_q <= '0;
      end else if (load) begin
         len_q <= len;
         pos_q <= '0;
      end else if (inc) begin
         pos_q <= pos_q + 1'b1;
      end
   end

   assign at_end  = (pos_q == len_q);
   assign at_last = (len_q != '0) && (pos_q == len_q - 1'b1);

   AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      pos_q <= len_q); // R3

endmodule

// File: rtl/i2cseq_timer.sv
module i2cseq_timer #(
   parameter int TMO_W       = 24,
   parameter bit USE_TIMEOUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             run,
   input  logic [TMO_W-1:0] limit,
   output logic             expired
);
   generate
      if (USE_TIMEOUT) begin : g_tmo
         localparam logic [TMO_W-1:0] CNT_MAX = {TMO_W{1'b1}};
         logic [TMO_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       cnt_q <= '0;
            else if (start)                   cnt_q <= '0;
            else if (run && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
         end

         assign expired = run && !start && (cnt_q >= limit);
      end else begin : g_no_tmo
         assign expired = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/i2cseq_fsm.sv
module i2cseq_fsm
   import i2cseq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic       tmo_expired,
   input  logic       desc_valid,
   output logic       desc_ready,
   input  logic [6:0] desc_addr,
   input  logic       desc_rd,
   input  logic       desc_nostart,
   input  logic       desc_last,
   input  logic       wr_valid,
   output logic       wr_ready,
   input  logic [7:0] wr_data,
   output logic       rd_valid,
   output logic [7:0] rd_data,
   output logic       cmd_valid,
   output logic [2:0] cmd_op,
   output logic [7:0] cmd_byte,
   input  logic       evt_done,
   input  logic       evt_nack,
   input  logic       evt_arblost,
   input  logic [7:0] evt_rxbyte,
   output logic       busy,
   output logic       xfer_done,
   output logic [1:0] xfer_status,
   output logic       launch,
   output logic       pos_load,
   output logic       pos_inc,
   input  logic       at_end,
   input  logic       at_last
);
   phase_e   ph_q, ph_d;
   act_e     act_q, act_d;
   cmd_op_e  op_q, op_d;
   xfer_st_e st_q, st_d;
   logic     busy_q, busy_d, first_q, first_d, rdm_q, rdm_d, last_q, last_d;
   logic     cv_q, cv_d, done_q, done_d, rv_q, rv_d;
   logic [7:0] byte_q, byte_d, rdat_q, rdat_d;

   always_comb begin
      ph_d = ph_q;  act_d = act_q;  op_d = op_q;  st_d = st_q;
      busy_d = busy_q;  first_d = first_q;  rdm_d = rdm_q;  last_d = last_q;
      cv_d = 1'b0;  done_d = 1'b0;  rv_d = 1'b0;
      byte_d = byte_q;  rdat_d = rdat_q;
      desc_ready = 1'b0;  wr_ready = 1'b0;
      pos_load = 1'b0;  pos_inc = 1'b0;  launch = 1'b0;
      if (!busy_q) begin
         if (go) begin
            launch = 1'b1;
            busy_d = 1'b1;  ph_d = PH_START;  act_d = ACT_FETCH;  first_d = 1'b1;
         end
      end else if (tmo_expired) begin
         busy_d = 1'b0;  ph_d = PH_IDLE;  act_d = ACT_WAIT;
         done_d = 1'b1;  st_d = ST_TIMEOUT;
      end else begin
         unique case (act_q)
            ACT_FETCH: begin
               desc_ready = 1'b1;
               if (desc_valid) begin
                  pos_load = 1'b1;
                  rdm_d = desc_rd;  last_d = desc_last;  first_d = 1'b0;
                  if (first_q || !desc_nostart) begin
                     cv_d = 1'b1;  op_d = OP_START_WR;  byte_d = {desc_addr, desc_rd};
                     ph_d = PH_START;  act_d = ACT_WAIT;
                  end else begin
                     ph_d = desc_rd ? PH_READ : PH_WRITE;
                     act_d = ACT_DATA;
                  end
               end
            end
            ACT_DATA: begin
               if (at_end) begin
                  if (last_q) begin
                     cv_d = 1'b1;  op_d = OP_STOP;  ph_d = PH_DONE;  act_d = ACT_WAIT;
                  end else begin
                     act_d = ACT_FETCH;
                  end
               end else if (ph_q == PH_READ) begin
                  cv_d = 1'b1;  op_d = at_last ? OP_RD_NACK : OP_RD_ACK;  act_d = ACT_WAIT;
               end else begin
                  wr_ready = 1'b1;
                  if (wr_valid) begin
                     cv_d = 1'b1;  op_d = OP_WR;  byte_d = wr_data;
                     pos_inc = 1'b1;  act_d = ACT_WAIT;
                  end
               end
            end
            default: begin
               if (evt_done) begin
                  if (ph_q == PH_DONE || ph_q == PH_ERROR) begin
                     cv_d = 1'b1;  op_d = OP_IACK;  done_d = 1'b1;  busy_d = 1'b0;
                     st_d = (ph_q == PH_DONE) ? ST_OK : ST_IOERR;  ph_d = PH_IDLE;
                  end else if (evt_arblost) begin
                     cv_d = 1'b1;  op_d = OP_STOP;  ph_d = PH_ERROR;
                  end else if (ph_q == PH_START || ph_q == PH_WRITE) begin
                     if (evt_nack) begin
                        cv_d = 1'b1;  op_d = OP_STOP;  ph_d = PH_ERROR;
                     end else begin
                        ph_d = rdm_q ? PH_READ : PH_WRITE;  act_d = ACT_DATA;
                     end
                  end else begin
                     rv_d = 1'b1;  rdat_d = evt_rxbyte;  pos_inc = 1'b1;  act_d = ACT_DATA;
                  end
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q <= PH_IDLE;  act_q <= ACT_WAIT;  op_q <= OP_IACK;  st_q <= ST_OK;
         busy_q <= 1'b0;  first_q <= 1'b0;  rdm_q <= 1'b0;  last_q <= 1'b0;
         cv_q <= 1'b0;  done_q <= 1'b0;  rv_q <= 1'b0;
         byte_q <= '0;  rdat_q <= '0;
      end else begin
         ph_q <= ph_d;  act_q <= act_d;  op_q <= op_d;  st_q <= st_d;
         busy_q <= busy_d;  first_q <= first_d;  rdm_q <= rdm_d;  last_q <= last_d;
         cv_q <= cv_d;  done_q <= done_d;  rv_q <= rv_d;
         byte_q <= byte_d;  rdat_q <= rdat_d;
      end
   end

   assign cmd_valid   = cv_q;
   assign cmd_op      = op_q;
   assign cmd_byte    = byte_q;
   assign busy        = busy_q;
   assign xfer_done   = done_q;
   assign xfer_status = st_q;
   assign rd_valid    = rv_q;
   assign rd_data     = rdat_q;

   // outstanding-command tracker for the single-command rule
   logic outst_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        outst_q <= 1'b0;
      else if (done_q)                   outst_q <= 1'b0;
      else if (cv_q && op_q != OP_IACK)  outst_q <= 1'b1;
      else if (evt_done)                 outst_q <= 1'b0;
   end

   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      cv_q |-> !outst_q); // R11
   AST_ADDR_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      desc_ready && desc_valid && !desc_nostart |=>
         cmd_valid && cmd_op == OP_START_WR && cmd_byte[7:1] == $past(desc_addr)); // R4
   AST_WR_POP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ready && wr_valid |=> cmd_valid && cmd_op == OP_WR && cmd_byte == $past(wr_data)); // R2
   AST_NACK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !tmo_expired && act_q == ACT_WAIT && evt_done && evt_nack && !evt_arblost &&
      (ph_q == PH_START || ph_q == PH_WRITE) |=> cmd_valid && cmd_op == OP_STOP); // R5
   AST_ARB_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !tmo_expired && act_q == ACT_WAIT && evt_done && evt_arblost &&
      ph_q != PH_DONE && ph_q != PH_ERROR |=> cmd_valid && cmd_op == OP_STOP); // R6
   AST_TMO_END: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && tmo_expired |=> xfer_done && xfer_status == ST_TIMEOUT && !busy); // R8
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> !busy); // R7

endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq
   import i2cseq_pkg::*;
#(
   parameter int LEN_W       = 8,
   parameter int TMO_W       = 24,
   parameter bit USE_TIMEOUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [TMO_W-1:0] tmo_limit,
   input  logic             desc_valid,
   output logic             desc_ready,
   input  logic [6:0]       desc_addr,
   input  logic             desc_rd,
   input  logic             desc_nostart,
   input  logic [LEN_W-1:0] desc_len,
   input  logic             desc_last,
   input  logic             wr_valid,
   output logic             wr_ready,
   input  logic [7:0]       wr_data,
   output logic             rd_valid,
   output logic [7:0]       rd_data,
   output logic             cmd_valid,
   output logic [2:0]       cmd_op,
   output logic [7:0]       cmd_byte,
   input  logic             evt_done,
   input  logic             evt_nack,
   input  logic             evt_arblost,
   input  logic [7:0]       evt_rxbyte,
   output logic             busy,
   output logic             xfer_done,
   output logic [1:0]       xfer_status
);
   generate
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
         $error("i2c_msg_seq: LEN_W must be 1..16");
      end
      if (TMO_W < 2 || TMO_W > 32) begin : g_bad_tmo
         $error("i2c_msg_seq: TMO_W must be 2..32");
      end
   endgenerate

   logic launch, tmo_expired, pos_load, pos_inc, at_end, at_last;

   i2cseq_timer #(.TMO_W(TMO_W), .USE_TIMEOUT(USE_TIMEOUT)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(launch), .run(busy),
      .limit(tmo_limit), .expired(tmo_expired));

   i2cseq_pos #(.LEN_W(LEN_W)) u_pos (
      .clk(clk), .rst_n(rst_n), .load(pos_load), .len(desc_len),
      .inc(pos_inc), .at_end(at_end), .at_last(at_last));

   i2cseq_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .go(go), .tmo_expired(tmo_expired),
      .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_addr(desc_addr),
      .desc_rd(desc_rd), .desc_nostart(desc_nostart), .desc_last(desc_last),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
      .evt_done(evt_done), .evt_nack(evt_nack), .evt_arblost(evt_arblost),
      .evt_rxbyte(evt_rxbyte), .busy(busy), .xfer_done(xfer_done),
      .xfer_status(xfer_status), .launch(launch), .pos_load(pos_load),
      .pos_inc(pos_inc), .at_end(at_end), .at_last(at_last));

endmodule

// File: tb/tb_i2c_msg_seq.sv
module tb_i2c_msg_seq;
   import i2cseq_pkg::*;

   localparam int LEN_W = 8;
   localparam int TMO_W = 24;

   typedef struct packed {
      logic [1:0]  nmsg;
      logic [13:0] m0;
      logic [13:0] m1;
      logic [7:0]  nack_at;
      logic [7:0]  arb_at;
      logic [1:0]  st;
   } scen_t;

   function automatic logic [13:0] mm(input logic [6:0] a, input logic rd,
                                      input logic ns, input logic [3:0] len);
      return {a, rd, ns, len};
   endfunction

   function automatic scen_t mk(input logic [1:0] n, input logic [13:0] a, input logic [13:0] b,
                                input logic [7:0] nk, input logic [7:0] ab, input logic [1:0] st);
      return '{nmsg: n, m0: a, m1: b, nack_at: nk, arb_at: ab, st: st};
   endfunction

   localparam int NSC = 8;
   localparam scen_t SCEN [NSC] = '{
      mk(2'd1, mm(7'h50,0,0,4'd2), 14'd0,            8'hFF, 8'hFF, 2'd0),
      mk(2'd1, mm(7'h23,1,0,4'd3), 14'd0,            8'hFF, 8'hFF, 2'd0),
      mk(2'd2, mm(7'h11,0,0,4'd1), mm(7'h11,1,0,4'd2), 8'hFF, 8'hFF, 2'd0),
      mk(2'd2, mm(7'h2A,0,0,4'd1), mm(7'h00,0,1,4'd2), 8'hFF, 8'hFF, 2'd0),
      mk(2'd1, mm(7'h40,0,0,4'd3), 14'd0,            8'd2,  8'hFF, 2'd1),
      mk(2'd1, mm(7'h33,1,0,4'd2), 14'd0,            8'hFF, 8'd1,  2'd1),
      mk(2'd2, mm(7'h22,0,0,4'd1), mm(7'h00,1,1,4'd0), 8'hFF, 8'hFF, 2'd0),
      mk(2'd1, mm(7'h5A,0,0,4'd2), 14'd0,            8'd0,  8'hFF, 2'd1)
   };

   function automatic string tag_of(input int i);
      case (i)
         0: return "R1 R2 R7";
         1: return "R1 R3";
         2: return "R4 R3";
         3: return "R4 nostart";
         4: return "R5";
         5: return "R6";
         6: return "R9";
         default: return "R5 addr";
      endcase
   endfunction

   logic clk = 1'b0, rst_n = 1'b0, go = 1'b0;
   logic [TMO_W-1:0] tmo_limit = 24'd1000;
   logic desc_valid, desc_ready, desc_rd, desc_nostart, desc_last;
   logic [6:0] desc_addr;
   logic [LEN_W-1:0] desc_len;
   logic wr_valid, wr_ready, rd_valid, cmd_valid, busy, xfer_done;
   logic [7:0] wr_data, rd_data, cmd_byte;
   logic [2:0] cmd_op;
   logic evt_done = 1'b0, evt_nack = 1'b0, evt_arblost = 1'b0;
   logic [7:0] evt_rxbyte = 8'h00;
   logic [1:0] xfer_status;

   always #5 clk = ~clk;

   i2c_msg_seq #(.LEN_W(LEN_W), .TMO_W(TMO_W)) dut (
      .clk(clk), .rst_n(rst_n), .go(go), .tmo_limit(tmo_limit),
      .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_addr(desc_addr),
      .desc_rd(desc_rd), .desc_nostart(desc_nostart), .desc_len(desc_len),
      .desc_last(desc_last), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
      .evt_done(evt_done), .evt_nack(evt_nack), .evt_arblost(evt_arblost),
      .evt_rxbyte(evt_rxbyte), .busy(busy), .xfer_done(xfer_done),
      .xfer_status(xfer_status));

   // stimulus streams
   scen_t cur = '0;
   logic idx_clr = 1'b0, wr_en = 1'b1, resp_en = 1'b1, log_clr = 1'b0;
   logic [1:0] desc_idx;
   logic [7:0] wcnt;
   logic [13:0] cur_m;

   assign cur_m        = (desc_idx == 2'd0) ? cur.m0 : cur.m1;
   assign desc_valid   = (desc_idx < cur.nmsg);
   assign desc_addr    = cur_m[13:7];
   assign desc_rd      = cur_m[6];
   assign desc_nostart = cur_m[5];
   assign desc_len     = {{(LEN_W-4){1'b0}}, cur_m[3:0]};
   assign desc_last    = (desc_idx == cur.nmsg - 2'd1);
   assign wr_valid     = wr_en;
   assign wr_data      = 8'hA0 + wcnt;

   always @(posedge clk) begin
      if (idx_clr) begin
         desc_idx <= 2'd0;
         wcnt     <= 8'd0;
      end else begin
         if (desc_valid && desc_ready) desc_idx <= desc_idx + 2'd1;
         if (wr_valid && wr_ready)     wcnt     <= wcnt + 8'd1;
      end
   end

   // byte-controller model and logging
   logic [2:0] log_op [64];
   logic [7:0] log_byte [64];
   logic [7:0] log_rd [64];
   int log_n = 0, rd_n = 0, dly = 0, pend_idx = 0;
   bit pend = 1'b0;

   always @(negedge clk) begin
      evt_done    = 1'b0;
      evt_nack    = 1'b0;
      evt_arblost = 1'b0;
      if (log_clr) begin
         log_n = 0;  rd_n = 0;  pend = 1'b0;
      end else begin
         if (pend) begin
            dly = dly - 1;
            if (dly == 0) begin
               pend        = 1'b0;
               evt_done    = 1'b1;
               evt_nack    = (pend_idx == int'(cur.nack_at));
               evt_arblost = (pend_idx == int'(cur.arb_at));
               evt_rxbyte  = 8'h30 + 8'(pend_idx);
            end
         end
         if (rd_valid && rd_n < 64) begin
            log_rd[rd_n] = rd_data;
            rd_n = rd_n + 1;
         end
         if (cmd_valid && log_n < 64) begin
            log_op[log_n]   = cmd_op;
            log_byte[log_n] = cmd_byte;
            if (cmd_op != OP_IACK && resp_en) begin
               pend = 1'b1;  dly = 3;  pend_idx = log_n;
            end
            log_n = log_n + 1;
         end
      end
   end

   // checking
   int checks = 0, failures = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   logic [2:0] exp_op [64];
   logic [7:0] exp_byte [64];
   logic [7:0] exp_rd [64];
   int exp_n, exp_rd_n;
   logic [1:0] exp_st;

   task automatic build_exp(input scen_t s);
      int ideal_n = 0, wc = 0, f;
      logic [13:0] m;
      for (int mi = 0; mi < int'(s.nmsg); mi++) begin
         m = (mi == 0) ? s.m0 : s.m1;
         if (mi == 0 || !m[5]) begin
            exp_op[ideal_n] = OP_START_WR;  exp_byte[ideal_n] = {m[13:7], m[6]};  ideal_n++;
         end
         for (int b = 0; b < int'(m[3:0]); b++) begin
            if (m[6]) begin
               exp_op[ideal_n] = (b == int'(m[3:0]) - 1) ? OP_RD_NACK : OP_RD_ACK;
               exp_byte[ideal_n] = 8'h00;
            end else begin
               exp_op[ideal_n] = OP_WR;  exp_byte[ideal_n] = 8'hA0 + 8'(wc);  wc++;
            end
            ideal_n++;
         end
      end
      exp_op[ideal_n] = OP_STOP;  exp_byte[ideal_n] = 8'h00;  ideal_n++;
      f = (s.nack_at != 8'hFF) ? int'(s.nack_at) : ((s.arb_at != 8'hFF) ? int'(s.arb_at) : -1);
      exp_rd_n = 0;
      for (int k = 0; k < ideal_n; k++)
         if ((exp_op[k] == OP_RD_ACK || exp_op[k] == OP_RD_NACK) && (f < 0 || k < f)) begin
            exp_rd[exp_rd_n] = 8'h30 + 8'(k);  exp_rd_n++;
         end
      if (f >= 0) begin
         exp_n = f + 1;
         exp_op[exp_n] = OP_STOP;  exp_n++;
         exp_st = 2'd1;
      end else begin
         exp_n = ideal_n;
         exp_st = 2'd0;
      end
      exp_op[exp_n] = OP_IACK;  exp_n++;
   endtask

   task automatic launch_scen(input scen_t s);
      cur = s;
      log_clr = 1'b1;  idx_clr = 1'b1;
      @(negedge clk);
      @(negedge clk);
      log_clr = 1'b0;  idx_clr = 1'b0;
      go = 1'b1;
      @(negedge clk);
      go = 1'b0;
   endtask

   task automatic wait_done(output bit got, output logic [1:0] st, output int cyc);
      got = 1'b0;  st = 2'd3;  cyc = 0;
      while (!got && cyc < 600) begin
         @(negedge clk);
         cyc++;
         if (xfer_done) begin
            got = 1'b1;  st = xfer_status;
         end
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic run_scen(input scen_t s, input string tag, input int stall);
      bit got;  logic [1:0] st;  int cyc;
      build_exp(s);
      if (stall > 0) wr_en = 1'b0;
      launch_scen(s);
      if (stall > 0) begin
         repeat (stall) @(negedge clk);
         chk(log_n == 1 && busy, "R2 stall", log_n, 1);
         wr_en = 1'b1;
      end
      wait_done(got, st, cyc);
      chk(got, {tag, " done"}, int'(got), 1);
      chk(st == s.st && st == exp_st, {tag, " status"}, int'(st), int'(exp_st));
      chk(log_n == exp_n, {tag, " cmd count"}, log_n, exp_n);
      for (int k = 0; k < exp_n && k < log_n; k++) begin
         chk(log_op[k] == exp_op[k], {tag, " cmd op"}, int'(log_op[k]), int'(exp_op[k]));
         if (exp_op[k] == OP_START_WR || exp_op[k] == OP_WR)
            chk(log_byte[k] == exp_byte[k], {tag, " cmd byte"}, int'(log_byte[k]), int'(exp_byte[k]));
      end
      chk(rd_n == exp_rd_n, {tag, " R3 rd count"}, rd_n, exp_rd_n);
      for (int k = 0; k < exp_rd_n && k < rd_n; k++)
         chk(log_rd[k] == exp_rd[k], {tag, " R3 rd data"}, int'(log_rd[k]), int'(exp_rd[k]));
   endtask

   bit wd_hit = 1'b0;
   initial begin
      repeat (100000) @(posedge clk);
      wd_hit = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      bit got;  logic [1:0] st;  int cyc;
      idx_clr = 1'b1;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(!busy && !cmd_valid && !xfer_done && !rd_valid, "R10 reset outputs", int'(busy), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!desc_ready && !wr_ready && !busy, "R10 idle after reset", int'(desc_ready), 0);

      for (int i = 0; i < NSC; i++) run_scen(SCEN[i], tag_of(i), 0);

      // R2: empty write stream stalls the engine
      run_scen(mk(2'd1, mm(7'h0C,0,0,4'd1), 14'd0, 8'hFF, 8'hFF, 2'd0), "R2 stall run", 30);

      // R8: no completion events, timeout after the programmed limit
      resp_en = 1'b0;
      tmo_limit = 24'd40;
      launch_scen(mk(2'd1, mm(7'h61,0,0,4'd1), 14'd0, 8'hFF, 8'hFF, 2'd0));
      wait_done(got, st, cyc);
      chk(got && st == 2'd2, "R8 timeout status", int'(st), 2);
      chk(cyc >= 38 && cyc <= 46, "R8 timeout latency", cyc, 42);
      chk(!busy, "R8 idle after timeout", int'(busy), 0);
      resp_en = 1'b1;
      tmo_limit = 24'd1000;

      // R8 vs R7: normal run after a timeout still reports OK
      run_scen(SCEN[0], "R8 recover R7", 0);

      if (!wd_hit) begin
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule